// File: doc/BRIEF.md
# Cyclic Sense Wake Sampler

This block saves standby power by keeping the supply of the external wake switches off most of the time. While the chip is asleep and cyclic sensing is enabled, it switches that supply on for a short window at a programmable interval. Partway through each window it takes one snapshot of every wake input.

Each input has a sensitivity mode: rising, falling, either direction, or off. An input is treated as a wake only when its recent snapshots show two at one level followed by two at the opposite level. A single noisy snapshot therefore never wakes the chip. When an input qualifies, its flag is set and the wake request is raised. Cycling then stops until sleep is entered again.

A forced-wake timer elsewhere in the chip may also be enabled. This block grants that timer a run permission only when cyclic sensing is off, so cyclic sensing always takes precedence. All time values are counted in ticks of a clock prescaler, so a bench can shrink the real-time figures in proportion.

Top module: `cysense_ctrl`

## Requirements
- R1: The 3-bit period code k sets the cycle length. For k from 0 to 6 it is BASE_TICKS·2^k ticks. For k = 7 it is BASE_TICKS·256 ticks. One tick is TICK_DIV clock cycles, and the cycle length is the distance between successive rises of the supply enable.
- R2: After each rise, the supply enable stays high for exactly ON_TICKS·TICK_DIV clock cycles.
- R3: Within each window the sample strobe is high for exactly one cycle, SAMPLE_TICKS·TICK_DIV cycles after the supply enable rises. All wake inputs are captured on that edge.
- R4: Sensitivity code 2'b01 (rising) qualifies an input when its last four captures, oldest first, are low, low, high, high. Other patterns, such as alternating levels, do not qualify.
- R5: Sensitivity code 2'b10 (falling) qualifies an input when its last four captures, oldest first, are high, high, low, low.
- R6: Sensitivity code 2'b11 (either) qualifies an input on low, low, high, high and on high, high, low, low.
- R7: Sensitivity code 2'b00 turns the input off. It never sets its flag, whatever pattern it shows.
- R8: The supply enable and the sample strobe stay low unless the sleep input and the cyclic-sense enable are both high.
- R9: The forced-wake permission output is high only while asleep, with forced wake enabled and cyclic sense disabled. It drops the cycle after cyclic sense is enabled.
- R10: When an input qualifies, its flag (input i at bit i) and the wake request rise on the strobe edge, and cycling stops. Flags, wake request and capture history are held until the next entry to sleep, which clears all of them.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Chip is in sleep mode |
| cyc_en_i | input | 1 | Cyclic sensing enabled |
| fwake_en_i | input | 1 | Forced-wake timer enabled |
| period_sel_i | input | 3 | Period code |
| edge_cfg_i | input | 2·N_IN | Sensitivity code, input i at bits 2i+1:2i |
| wake_in_i | input | N_IN | Wake input levels |
| sense_en_o | output | 1 | Sense supply enable |
| sample_stb_o | output | 1 | One-cycle capture strobe |
| wake_flag_o | output | N_IN | Per-input qualified-wake flags |
| wake_req_o | output | 1 | Wake request |
| fwake_run_o | output | 1 | Forced-wake timer run permission |

## Verification
The bench builds the block with three inputs, a two-cycle tick, a base period of ten ticks, a four-tick window and a three-tick sample offset. With these values each period code gives a cycle length that can be predicted exactly, from 20 to 5120 clock cycles. Even the longest, the quadrupled last step, can be measured edge to edge. Because cycles are short, many captures fit in a run, so the four-capture patterns, the alternating-level pattern that must not qualify, and the clearing of history on sleep entry can all be driven one capture at a time.

// File: rtl/cysense_pkg.sv
package cysense_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Codes 0..6 double each step; code 7 jumps to 256x the base.
  function automatic int unsigned period_shift(input logic [2:0] code);
    return (code == 3'd7) ? 32'd8 : {29'd0, code};
  endfunction

endpackage

// File: rtl/cysense_timer.sv
module cysense_timer
  import cysense_pkg::*;
#(
  parameter int TICK_DIV     = 5000,
  parameter int ON_TICKS     = 4,
  parameter int SAMPLE_TICKS = 3,
  parameter int BASE_TICKS   = 320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [2:0] code_i,
  output logic       en_o,
  output logic       samp_o
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int POS_W = $clog2(BASE_TICKS * 256 + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [POS_W-1:0] ON_P     = POS_W'(ON_TICKS);
  localparam logic [POS_W-1:0] SAMP_P   = POS_W'(SAMPLE_TICKS);
  localparam logic [POS_W-1:0] POS_MAX  = POS_W'(BASE_TICKS * 256 - 1);

  logic [DIV_W-1:0] div_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] per_last;

  always_comb begin
    per_last = (POS_W'(BASE_TICKS) << period_shift(code_i)) - POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      div_q <= '0;
      pos_q <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      pos_q <= (pos_q >= per_last) ? '0 : pos_q + POS_W'(1);
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  assign en_o   = run_i && (pos_q < ON_P);
  assign samp_o = run_i && (pos_q == SAMP_P) && (div_q == '0);

  // R1
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= POS_MAX);

endmodule

// File: rtl/cysense_edge.sv
module cysense_edge
  import cysense_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       samp_i,
  input  logic       full_i,
  input  logic [1:0] mode_i,
  input  logic       din_i,
  output logic       hit_o,
  output logic       flag_o
);

  logic [3:0] hist_q;
  logic [3:0] hist_n;
  logic       match;
  edge_mode_e mode;

  assign mode   = edge_mode_e'(mode_i);
  assign hist_n = {hist_q[2:0], din_i};

  always_comb begin
    unique case (mode)
      EDGE_RISE: match = (hist_n == 4'b0011);
      EDGE_FALL: match = (hist_n == 4'b1100);
      EDGE_ANY:  match = (hist_n == 4'b0011) || (hist_n == 4'b1100);
      default:   match = 1'b0;
    endcase
  end

  assign hit_o = samp_i && full_i && match;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      hist_q <= '0;
      flag_o <= 1'b0;
    end else if (samp_i) begin
      hist_q <= hist_n;
      if (hit_o) flag_o <= 1'b1;
    end
  end

  // R10
  flag_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(samp_i));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    flag_o && !clr_i |=> flag_o);

endmodule

// File: rtl/cysense_ctrl.sv
module cysense_ctrl
  import cysense_pkg::*;
#(
  parameter int N_IN         = 4,
  parameter int TICK_DIV     = 5000,
  parameter int ON_TICKS     = 4,
  parameter int SAMPLE_TICKS = 3,
  parameter int BASE_TICKS   = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              cyc_en_i,
  input  logic              fwake_en_i,
  input  logic [2:0]        period_sel_i,
  input  logic [2*N_IN-1:0] edge_cfg_i,
  input  logic [N_IN-1:0]   wake_in_i,
  output logic              sense_en_o,
  output logic              sample_stb_o,
  output logic [N_IN-1:0]   wake_flag_o,
  output logic              wake_req_o,
  output logic              fwake_run_o
);

  logic            sleep_q;
  logic            entry;
  logic            halted_q;
  logic            run;
  logic            en_c;
  logic            samp_c;
  logic [1:0]      cnt_q;
  logic            full;
  logic [N_IN-1:0] hits;

  assign entry = sleep_i && !sleep_q;
  assign run   = sleep_i && cyc_en_i && !halted_q && !entry;
  assign full  = (cnt_q == 2'd3);

  cysense_timer #(
    .TICK_DIV    (TICK_DIV),
    .ON_TICKS    (ON_TICKS),
    .SAMPLE_TICKS(SAMPLE_TICKS),
    .BASE_TICKS  (BASE_TICKS)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run_i (run),
    .code_i(period_sel_i),
    .en_o  (en_c),
    .samp_o(samp_c)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    cysense_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .clr_i (entry),
      .samp_i(samp_c),
      .full_i(full),
      .mode_i(edge_cfg_i[2*i +: 2]),
      .din_i (wake_in_i[i]),
      .hit_o (hits[i]),
      .flag_o(wake_flag_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q      <= 1'b0;
      halted_q     <= 1'b0;
      cnt_q        <= '0;
      wake_req_o   <= 1'b0;
      sense_en_o   <= 1'b0;
      sample_stb_o <= 1'b0;
      fwake_run_o  <= 1'b0;
    end else begin
      sleep_q      <= sleep_i;
      sense_en_o   <= en_c;
      sample_stb_o <= samp_c;
      fwake_run_o  <= sleep_i && fwake_en_i && !cyc_en_i;
      if (entry) begin
        halted_q   <= 1'b0;
        cnt_q      <= '0;
        wake_req_o <= 1'b0;
      end else begin
        if (|hits) begin
          halted_q   <= 1'b1;
          wake_req_o <= 1'b1;
        end
        if (samp_c && !full) cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  // R8
  no_sense_awake_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_i |=> !sense_en_o);

  // R3
  sample_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb_o |-> sense_en_o);

  // R9
  fwake_suppressed_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_en_i |=> !fwake_run_o);

  // R10
  halt_after_wake_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req_o && $past(wake_req_o) |-> !sense_en_o);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req_o && !(sleep_i && !sleep_q) |=> wake_req_o);

  // R10
  req_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_req_o) |-> sample_stb_o);

endmodule

// File: tb/cysense_ctrl_test.sv
module cysense_ctrl_test;

  localparam int N   = 3;
  localparam int DIV = 2;
  localparam int ON  = 4;
  localparam int SMP = 3;
  localparam int BAS = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sleep_i = 1'b0;
  logic         cyc_en_i = 1'b0;
  logic         fwake_en_i = 1'b0;
  logic [2:0]   period_sel_i = 3'd0;
  logic [2*N-1:0] edge_cfg_i = '0;
  logic [N-1:0] wake_in_i = '0;
  logic         sense_en_o;
  logic         sample_stb_o;
  logic [N-1:0] wake_flag_o;
  logic         wake_req_o;
  logic         fwake_run_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cysense_ctrl #(
    .N_IN(N), .TICK_DIV(DIV), .ON_TICKS(ON),
    .SAMPLE_TICKS(SMP), .BASE_TICKS(BAS)
  ) uut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .cyc_en_i(cyc_en_i),
    .fwake_en_i(fwake_en_i), .period_sel_i(period_sel_i),
    .edge_cfg_i(edge_cfg_i), .wake_in_i(wake_in_i),
    .sense_en_o(sense_en_o), .sample_stb_o(sample_stb_o),
    .wake_flag_o(wake_flag_o), .wake_req_o(wake_req_o),
    .fwake_run_o(fwake_run_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter_sleep();
    sleep_i = 1'b0;
    repeat (2) @(negedge clk);
    sleep_i = 1'b1;
    @(negedge clk);
  endtask

  // Drive a level, then wait until the strobe shows it was captured.
  task automatic feed(input logic [N-1:0] v);
    int n = 0;
    wake_in_i = v;
    @(negedge clk);
    while (!sample_stb_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_rise(output int t);
    int n = 0;
    while (sense_en_o && n < 20000) begin @(negedge clk); n++; end
    while (!sense_en_o && n < 20000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic t_reset();
    // R11
    chk({sense_en_o, sample_stb_o, wake_flag_o, wake_req_o, fwake_run_o} == '0,
        "R11 outputs after reset",
        int'({sense_en_o, sample_stb_o, wake_flag_o, wake_req_o, fwake_run_o}), 0);
  endtask

  task automatic t_not_sleep();
    int hi = 0;
    sleep_i = 1'b0; cyc_en_i = 1'b1;
    repeat (200) begin @(negedge clk); hi += int'(sense_en_o | sample_stb_o); end
    chk(hi == 0, "R8 awake with cyclic enabled", hi, 0);
    sleep_i = 1'b1; cyc_en_i = 1'b0; hi = 0;
    repeat (200) begin @(negedge clk); hi += int'(sense_en_o | sample_stb_o); end
    chk(hi == 0, "R8 asleep with cyclic disabled", hi, 0);
  endtask

  task automatic t_timing(input logic [2:0] code, input int mult);
    int t0, t1, t2, ts, nstb;
    period_sel_i = code;
    cyc_en_i = 1'b1;
    edge_cfg_i = '0;
    enter_sleep();
    wait_rise(t0);
    ts = 0; nstb = 0;
    while (sense_en_o) begin
      if (sample_stb_o) begin nstb++; ts = cyc; end
      @(negedge clk);
    end
    t1 = cyc;
    wait_rise(t2);
    chk(t2 - t0 == BAS * mult * DIV, "R1 period", t2 - t0, BAS * mult * DIV);
    chk(t1 - t0 == ON * DIV, "R2 window width", t1 - t0, ON * DIV);
    chk(ts - t0 == SMP * DIV, "R3 sample offset", ts - t0, SMP * DIV);
    chk(nstb == 1, "R3 strobes per window", nstb, 1);
  endtask

  task automatic t_fwake();
    sleep_i = 1'b1; fwake_en_i = 1'b1; cyc_en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(fwake_run_o == 1'b1, "R9 forced wake alone", int'(fwake_run_o), 1);
    cyc_en_i = 1'b1;
    @(negedge clk);
    chk(fwake_run_o == 1'b0, "R9 cyclic takes precedence", int'(fwake_run_o), 0);
    fwake_en_i = 1'b0;
  endtask

  task automatic t_rise();
    int hi = 0;
    period_sel_i = 3'd0; cyc_en_i = 1'b1;
    edge_cfg_i = {2'b00, 2'b10, 2'b01};
    enter_sleep();
    feed(3'b000); feed(3'b000); feed(3'b101);
    chk(wake_flag_o == 3'b000, "R4 no flag after three captures", int'(wake_flag_o), 0);
    feed(3'b101);
    // R4 rising qualifies; R7 input 2 (off) ignored with the same pattern
    chk(wake_flag_o == 3'b001, "R4 R7 flags after low low high high", int'(wake_flag_o), 1);
    chk(wake_req_o == 1'b1, "R10 wake request raised", int'(wake_req_o), 1);
    repeat (3) @(negedge clk);
    repeat (BAS * DIV * 3) begin @(negedge clk); hi += int'(sense_en_o); end
    chk(hi == 0, "R10 cycling stopped", hi, 0);
    chk(wake_flag_o == 3'b001 && wake_req_o, "R10 flags held", int'(wake_flag_o), 1);
  endtask

  task automatic t_fall();
    edge_cfg_i = {2'b00, 2'b10, 2'b01};
    enter_sleep();
    chk(wake_flag_o == 3'b000 && !wake_req_o, "R10 cleared on sleep entry",
        int'({wake_req_o, wake_flag_o}), 0);
    feed(3'b111); feed(3'b111); feed(3'b000); feed(3'b000);
    chk(wake_flag_o == 3'b010, "R5 falling qualifies", int'(wake_flag_o), 2);
  endtask

  task automatic t_any();
    edge_cfg_i = {2'b11, 2'b00, 2'b00};
    enter_sleep();
    feed(3'b111); feed(3'b111); feed(3'b000); feed(3'b000);
    chk(wake_flag_o == 3'b100, "R6 either edge, falling", int'(wake_flag_o), 4);
    enter_sleep();
    feed(3'b000); feed(3'b000); feed(3'b111); feed(3'b111);
    chk(wake_flag_o == 3'b100, "R6 either edge, rising", int'(wake_flag_o), 4);
  endtask

  task automatic t_glitch();
    edge_cfg_i = {2'b00, 2'b00, 2'b01};
    enter_sleep();
    for (int i = 0; i < 6; i++) feed((i % 2 == 0) ? 3'b000 : 3'b001);
    chk(wake_flag_o == 3'b000 && !wake_req_o, "R4 alternating does not qualify",
        int'({wake_req_o, wake_flag_o}), 0);
  endtask

  task automatic t_history_clear();
    edge_cfg_i = {2'b00, 2'b00, 2'b01};
    enter_sleep();
    feed(3'b000); feed(3'b000);
    enter_sleep();
    feed(3'b001); feed(3'b001);
    chk(wake_flag_o == 3'b000, "R10 history cleared on entry", int'(wake_flag_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_not_sleep();
    t_timing(3'd0, 1);
    t_timing(3'd2, 4);
    t_timing(3'd6, 64);
    t_timing(3'd7, 256);
    t_fwake();
    t_rise();
    t_fall();
    t_any();
    t_glitch();
    t_history_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule